// File: doc/BRIEF.md
# Addressable RGB LED Waveform Encoder

This block drives the data line of a daisy-chained string of addressable RGB LEDs. Each 24-bit pixel word arrives from an upstream FIFO. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0. The encoder reorders the three colour bytes into the order the LEDs expect. It then sends every bit as a high pulse followed by a low pulse. The widths of these pulses are counted in clock cycles and set separately for 0 bits and 1 bits.

A transfer begins with a start pulse while the block is idle. The pulse latches the number of pixel words to send. The encoder pops one word from the FIFO for each pixel. When the FIFO runs dry it waits with the line low. After the last bit it holds the line low for a programmed latch period. It then emits a one-cycle done pulse and returns to idle. The timing widths, the latch period and the byte order are plain input ports that a register file elsewhere drives.

Top module: `rgb_chain_encoder`

## Requirements
- R1: During and after reset, with no transfer running, `dout` is low and `busy`, `done` and `fifo_pop` are low.
- R2: A `start` pulse while idle raises `busy` and samples `word_count`. A `start` while `busy` is ignored: the transfer pops and sends exactly the originally sampled number of words.
- R3: `order_sel` picks the on-wire byte order: 0=R,G,B; 1=R,B,G; 2=G,R,B; 3=G,B,R; 4=B,R,G; 5=B,G,R. Codes 6 and 7 behave as code 2.
- R4: Within each byte, bits leave most significant first.
- R5: A 1 bit is `hi1` cycles high then `lo1` cycles low. A 0 bit is `hi0` cycles high then `lo0` cycles low. The widths are 6, 5, 5 and 6 bits wide respectively.
- R6: Any timing or latch count of zero acts as one cycle.
- R7: After the low phase of the final bit, `dout` stays low for `latch_len` more cycles. `done` is then high for exactly one cycle, and `busy` is low in that same cycle.
- R8: If the FIFO is empty when a word is needed, `dout` stays low, `fifo_pop` stays low and `busy` stays high until data arrives. Sending then resumes.
- R9: Exactly one word is popped per pixel. When the next word is already available, the first bit of the next pixel follows the last bit of the previous one with no extra cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; all pulse widths count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a transfer when idle |
| word_count | input | 13 | Number of pixel words, sampled at start |
| order_sel | input | 3 | On-wire colour byte order |
| hi1 | input | 6 | High cycles of a 1 bit |
| lo1 | input | 5 | Low cycles of a 1 bit |
| hi0 | input | 5 | High cycles of a 0 bit |
| lo0 | input | 6 | Low cycles of a 0 bit |
| latch_len | input | 13 | Low cycles after the last bit |
| fifo_valid | input | 1 | Upstream FIFO holds a word |
| fifo_data | input | 24 | Head word of the FIFO, R/G/B from high to low byte |
| fifo_pop | output | 1 | Consumes the head word this cycle |
| dout | output | 1 | Serial LED data line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer-finished pulse |

## Verification
A wrong shift register or byte mux shows up on `dout` as a high phase of the wrong width. This is visible at the falling edge of the very bit concerned, within one bit cell. A faulty phase counter shows up the same way, as a wrong high or low run length. A bad word counter shows up at the end of the transfer. There, the number of bit cells seen before `done`, the number of pops, or the low gap before `done` differs from expectation. An error in the state sequencing shows up in the stall and start-while-busy cases. There, `fifo_pop`, `busy` or `dout` moves in a cycle where it must stay put.

// File: rtl/rgb_chain_encoder.sv
module rgb_chain_encoder #(
  parameter int LEN_W   = 13,
  parameter int LATCH_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   word_count,
  input  logic [2:0]         order_sel,
  input  logic [5:0]         hi1,
  input  logic [4:0]         lo1,
  input  logic [4:0]         hi0,
  input  logic [5:0]         lo0,
  input  logic [LATCH_W-1:0] latch_len,
  input  logic               fifo_valid,
  input  logic [23:0]        fifo_data,
  output logic               fifo_pop,
  output logic               dout,
  output logic               busy,
  output logic               done
);
  localparam int CW = LATCH_W;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_HIGH, S_LOW, S_LATCH} state_t;

  state_t        st;
  logic [23:0]   shreg;
  logic [4:0]    bit_idx;
  logic [LEN_W-1:0] left;
  logic [CW-1:0] cnt;
  logic          done_q;

  function automatic logic [23:0] reorder(input logic [23:0] px, input logic [2:0] sel);
    logic [7:0] r, g, b;
    r = px[23:16];
    g = px[15:8];
    b = px[7:0];
    case (sel)
      3'd0:    return {r, g, b};
      3'd1:    return {r, b, g};
      3'd3:    return {g, b, r};
      3'd4:    return {b, r, g};
      3'd5:    return {b, g, r};
      default: return {g, r, b};
    endcase
  endfunction

  function automatic logic [CW-1:0] nz(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  logic [23:0]   nxt;
  logic [CW-1:0] hi_nxt, hi_follow, lo_cur, latch_eff;
  logic          phase_end, last_bit, more;

  assign nxt       = reorder(fifo_data, order_sel);
  assign hi_nxt    = nz(nxt[23]   ? CW'(hi1) : CW'(hi0));
  assign hi_follow = nz(shreg[22] ? CW'(hi1) : CW'(hi0));
  assign lo_cur    = nz(shreg[23] ? CW'(lo1) : CW'(lo0));
  assign latch_eff = nz(latch_len);
  assign phase_end = (cnt == CW'(1));
  assign last_bit  = (bit_idx == 5'd0);
  assign more      = (left > LEN_W'(1));

  assign fifo_pop = fifo_valid &&
                    ((st == S_FETCH) || (st == S_LOW && phase_end && last_bit && more));
  assign dout = (st == S_HIGH);
  assign busy = (st != S_IDLE);
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      left    <= '0;
      cnt     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          left <= word_count;
          if (word_count == '0) begin
            cnt <= latch_eff;
            st  <= S_LATCH;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (fifo_valid) begin
          shreg   <= nxt;
          bit_idx <= 5'd23;
          cnt     <= hi_nxt;
          st      <= S_HIGH;
        end
        S_HIGH: if (phase_end) begin
          cnt <= lo_cur;
          st  <= S_LOW;
        end else begin
          cnt <= cnt - CW'(1);
        end
        S_LOW: if (phase_end) begin
          if (!last_bit) begin
            shreg   <= {shreg[22:0], 1'b0};
            bit_idx <= bit_idx - 5'd1;
            cnt     <= hi_follow;
            st      <= S_HIGH;
          end else begin
            left <= left - LEN_W'(1);
            if (!more) begin
              cnt <= latch_eff;
              st  <= S_LATCH;
            end else if (fifo_valid) begin
              shreg   <= nxt;
              bit_idx <= 5'd23;
              cnt     <= hi_nxt;
              st      <= S_HIGH;
            end else begin
              st <= S_FETCH;
            end
          end
        end else begin
          cnt <= cnt - CW'(1);
        end
        S_LATCH: if (phase_end) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else begin
          cnt <= cnt - CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rgb_chain_encoder_checks.sv
module rgb_chain_encoder_checks (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic fifo_valid,
  input logic fifo_pop,
  input logic dout,
  input logic busy,
  input logic done
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dout && !fifo_pop));

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_pop_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_valid && busy));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !dout));

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

bind rgb_chain_encoder rgb_chain_encoder_checks u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .fifo_valid(fifo_valid),
  .fifo_pop(fifo_pop), .dout(dout), .busy(busy), .done(done)
);

// File: tb/rgb_chain_encoder_test.sv
module rgb_chain_encoder_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] word_count = '0;
  logic [2:0]  order_sel = 3'd2;
  logic [5:0]  hi1 = '0;
  logic [4:0]  lo1 = '0;
  logic [4:0]  hi0 = '0;
  logic [5:0]  lo0 = '0;
  logic [12:0] latch_len = '0;
  logic        fifo_valid, fifo_pop, dout, busy, done;
  logic [23:0] fifo_data;

  logic [23:0] fifo_mem [0:63];
  int wr_ptr = 0;
  int rd_ptr = 0;
  assign fifo_valid = rd_ptr < wr_ptr;
  assign fifo_data  = fifo_mem[rd_ptr % 64];
  always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 1;

  always #(CLK_NS/2) clk = ~clk;

  rgb_chain_encoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
    .order_sel(order_sel), .hi1(hi1), .lo1(lo1), .hi0(hi0), .lo0(lo0),
    .latch_len(latch_len), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .dout(dout), .busy(busy), .done(done)
  );

  int nchk = 0;
  int nerr = 0;
  int exp_hi [0:2047];
  int exp_lo [0:2047];
  int nbits = 0;
  int mi = 0;
  int run = 0;
  logic prev = 1'b0;
  bit mon_en = 1'b0;
  bit lax = 1'b0;
  int done_seen = 0;
  string tag = "R5";

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [23:0] wire_order(input logic [23:0] px, input logic [2:0] sel);
    logic [7:0] c [0:2];
    int k0, k1, k2;
    c[0] = px[23:16]; c[1] = px[15:8]; c[2] = px[7:0];
    case (sel)
      3'd0: begin k0 = 0; k1 = 1; k2 = 2; end
      3'd1: begin k0 = 0; k1 = 2; k2 = 1; end
      3'd3: begin k0 = 1; k1 = 2; k2 = 0; end
      3'd4: begin k0 = 2; k1 = 0; k2 = 1; end
      3'd5: begin k0 = 2; k1 = 1; k2 = 0; end
      default: begin k0 = 1; k1 = 0; k2 = 2; end
    endcase
    return {c[k0], c[k1], c[k2]};
  endfunction

  task automatic push(input logic [23:0] px, input bit expect_it);
    logic [23:0] o;
    fifo_mem[wr_ptr % 64] = px;
    wr_ptr++;
    if (expect_it) begin
      o = wire_order(px, order_sel);
      for (int b = 23; b >= 0; b--) begin
        exp_hi[nbits] = o[b] ? eff(int'(hi1)) : eff(int'(hi0));
        exp_lo[nbits] = o[b] ? eff(int'(lo1)) : eff(int'(lo0));
        nbits++;
      end
    end
  endtask

  task automatic arm();
    mi = 0; nbits = 0; run = 0; prev = 1'b0; done_seen = 0; mon_en = 1'b1;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (done) begin
        done_seen++;
        chk(run == exp_lo[nbits-1] + eff(int'(latch_len)), "R7 latch gap", run,
            exp_lo[nbits-1] + eff(int'(latch_len)));
        chk(mi == nbits, "R2 bit cells sent", mi, nbits);
        chk(!busy, "R7 busy low with done", int'(busy), 0);
      end
      if (dout && !prev) begin
        if (mi > 0)
          chk(lax ? (run >= exp_lo[mi-1]) : (run == exp_lo[mi-1]), tag, run, exp_lo[mi-1]);
        run = 1;
      end else if (!dout && prev) begin
        chk(mi < nbits && run == exp_hi[mi], tag, run, exp_hi[mi]);
        mi++;
        run = 1;
      end else begin
        run++;
      end
      prev = dout;
    end
  end

  task automatic pulse_start(input int cnt);
    @(negedge clk);
    word_count = 13'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (done_seen == 0 && t < 30000) begin
      @(negedge clk);
      t++;
    end
    chk(done_seen == 1, "R7 done seen", done_seen, 1);
    @(negedge clk);
    chk(!done && !busy, "R7 one-cycle done", int'(done), 0);
    mon_en = 1'b0;
  endtask

  task automatic timing(input int a, input int b, input int c, input int d, input int l);
    hi1 = 6'(a); lo1 = 5'(b); hi0 = 5'(c); lo0 = 6'(d); latch_len = 13'(l);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int base, seed;
    logic [23:0] px;
    seed = $urandom(32'd1234);

    repeat (3) @(negedge clk);
    chk(!dout && !busy && !done && !fifo_pop, "R1 in reset", int'(dout), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!dout && !busy && !done && !fifo_pop, "R1 idle", int'(busy), 0);

    // R3 R4 R5 R9: two GRB words back to back
    timing(9, 4, 3, 8, 20);
    order_sel = 3'd2;
    tag = "R5 R4 R9 widths";
    arm();
    base = rd_ptr;
    push(24'hA5_3C_0F, 1); push(24'h81_FE_42, 1);
    pulse_start(2);
    wait_done();
    chk(rd_ptr - base == 2, "R9 pops", rd_ptr - base, 2);

    // R3: each order code
    for (int s = 0; s < 8; s++) begin
      order_sel = 3'(s);
      tag = "R3 order";
      arm();
      base = rd_ptr;
      push(24'h12_B7_E9 ^ 24'(s * 24'h010305), 1);
      pulse_start(1);
      wait_done();
      chk(rd_ptr - base == 1, "R3 pop", rd_ptr - base, 1);
    end

    // R6: zero counts act as one cycle
    timing(0, 0, 0, 0, 0);
    order_sel = 3'd0;
    tag = "R6 zero width";
    arm();
    push(24'hF0_0F_5A, 1);
    pulse_start(1);
    wait_done();

    // R8: underrun stall
    timing(5, 3, 2, 6, 10);
    order_sel = 3'd5;
    tag = "R8 stall";
    lax = 1'b1;
    arm();
    base = rd_ptr;
    push(24'h33_CC_99, 1);
    pulse_start(2);
    while (mi < 24) @(negedge clk);
    repeat (30) begin
      @(negedge clk);
      chk(!dout && !fifo_pop && busy, "R8 held low", int'(dout), 0);
    end
    push(24'h6E_01_D4, 1);
    wait_done();
    chk(rd_ptr - base == 2, "R8 resumed pops", rd_ptr - base, 2);
    lax = 1'b0;

    // R2: start while busy is ignored
    timing(4, 6, 3, 7, 12);
    order_sel = 3'd1;
    tag = "R2 busy start";
    arm();
    base = rd_ptr;
    push(24'h5D_A0_17, 1);
    push(24'hC3_3C_81, 0);
    push(24'h09_90_FF, 0);
    pulse_start(1);
    repeat (20) @(negedge clk);
    pulse_start(3);
    wait_done();
    chk(rd_ptr - base == 1, "R2 ignored start", rd_ptr - base, 1);
    // drain the two leftover words in a fresh transfer
    arm();
    o_drain: for (int k = 0; k < 2; k++) begin
      px = fifo_mem[(base + 1 + k) % 64];
      for (int b = 23; b >= 0; b--) begin
        logic [23:0] o;
        o = wire_order(px, order_sel);
        exp_hi[nbits] = o[b] ? eff(int'(hi1)) : eff(int'(hi0));
        exp_lo[nbits] = o[b] ? eff(int'(lo1)) : eff(int'(lo0));
        nbits++;
      end
    end
    pulse_start(2);
    wait_done();
    chk(rd_ptr == wr_ptr, "R9 drained", rd_ptr, wr_ptr);

    // random transfers
    for (int n = 0; n < 6; n++) begin
      int cnt;
      timing($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12),
             $urandom_range(0, 12), $urandom_range(0, 40));
      order_sel = 3'($urandom_range(0, 7));
      tag = "R5 R3 random";
      cnt = $urandom_range(1, 4);
      arm();
      base = rd_ptr;
      for (int k = 0; k < cnt; k++) push(24'($urandom), 1);
      pulse_start(cnt);
      wait_done();
      chk(rd_ptr - base == cnt, "R9 random pops", rd_ptr - base, cnt);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule